// File: doc/BRIEF.md
# Vector Element Write-Enable Policy Unit

This combinational block decides, for one destination vector register group, which bytes a vector instruction may write and what data they receive. It takes the active vector length, the element width code, the per-element predicate bits held in vector register zero, a flag that says whether the instruction is predicated, and two policy bits. One policy bit governs elements past the vector length. The other governs elements whose predicate bit is clear.

Each element index is sorted into one of three classes: body-active, body-inactive or tail. The class and the matching policy bit then give one of three actions: write the computed result, keep the old destination value, or fill the element with all ones. When a policy is agnostic, the unit always fills with ones. The result is a deterministic merged write word that the register file can store, together with a byte write-enable vector.

The unit sits between the execution datapath and the register file write port. It receives the old destination contents and the newly computed contents, both as flat words of the whole register group.

Top module: `vec_wr_policy`

## Requirements
- R1: An element whose index is greater than or equal to `vl_i` is a tail element. Its slot in `elem_cls_o` reads class code 0. Class codes are 0 = tail, 1 = body-active, 2 = body-inactive, and slot i sits at bits [2i+1:2i].
- R2: When `tail_agn_i` is 0, every byte of a tail element has `byte_we_o` low and `wdata_o` equal to the old data byte.
- R3: When `tail_agn_i` is 1, every byte of a tail element has `byte_we_o` high and `wdata_o` equal to 8'hFF. The element's action code in `elem_act_o` is 2. Action codes are 0 = keep old, 1 = write result, 2 = fill ones.
- R4: When `masked_i` is 1, a body element i with bit i of `v0_i` set is active. Its action code is 1, its bytes have `byte_we_o` high, and `wdata_o` carries the new data.
- R5: When `masked_i` is 1, a body element i with bit i of `v0_i` clear is inactive (class code 2). If `mask_agn_i` is 0, its bytes are not written and `wdata_o` carries the old data.
- R6: When an inactive element meets `mask_agn_i` = 1, its bytes are written with 8'hFF and its action code is 2.
- R7: When `masked_i` is 0, every element below `vl_i` is active whatever the value of `v0_i`. In that case no slot reports class code 2.
- R8: `sew_i` codes 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Element i occupies bits [i*SEW +: SEW] of the data words. All bytes of an element take the same action.
- R9: When `vl_i` is 0, all elements are tail. When `vl_i` is at or above the element count of the group at the current width, no element is tail.
- R10: Slots of `elem_cls_o` and `elem_act_o` whose index is at or beyond the element count of the group at the current width report tail class (0) and keep action (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vl_i | input | VL_W | Active vector length in elements |
| sew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| masked_i | input | 1 | Instruction is predicated by v0 |
| tail_agn_i | input | 1 | Tail policy: 1 = fill ones, 0 = keep old |
| mask_agn_i | input | 1 | Inactive policy: 1 = fill ones, 0 = keep old |
| v0_i | input | MAX_ELEM | Predicate bits, bit i for element i |
| old_data_i | input | GRP_BITS | Previous destination group contents |
| new_data_i | input | GRP_BITS | Computed result for the group |
| byte_we_o | output | GRP_BYTES | Per-byte write enable |
| wdata_o | output | GRP_BITS | Merged write data |
| elem_cls_o | output | 2*MAX_ELEM | Per-element class code |
| elem_act_o | output | 2*MAX_ELEM | Per-element action code |

## Verification
The bound checker inspects every input combination the bench applies. Any byte left unwritten must carry the old data. Any written byte must carry either the new data or all ones. Unpredicated operations must report no inactive element, every slot at or past `vl_i` must read as tail, and an empty vector length under a keep-old tail policy must write nothing. Other properties depend on the input pattern and are shown only by the directed scenarios: which bytes belong to which element at each width, the exact choice between result and fill for a given predicate pattern, and the reporting of non-existent slots at wide elements.

// File: rtl/vwp_pkg.sv
package vwp_pkg;

   localparam logic [1:0] CLS_TAIL  = 2'd0;
   localparam logic [1:0] CLS_ACT   = 2'd1;
   localparam logic [1:0] CLS_INACT = 2'd2;

   localparam logic [1:0] ACT_KEEP   = 2'd0;
   localparam logic [1:0] ACT_RESULT = 2'd1;
   localparam logic [1:0] ACT_ONES   = 2'd2;

   localparam int unsigned N_SEW_CODES = 4;

   function automatic int unsigned sew_bits(input int unsigned code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/vwp_elem_class.sv
module vwp_elem_class #(
   parameter int unsigned N_ELEM = 16,
   parameter int unsigned VL_W   = 5
) (
   input  logic [VL_W-1:0]         vl_i,
   input  logic                    masked_i,
   input  logic [N_ELEM-1:0]       pred_i,
   output logic [N_ELEM-1:0][1:0]  cls_o
);
   import vwp_pkg::*;

   initial begin
      if (N_ELEM >= (1 << VL_W))
         $fatal(1, "vwp_elem_class: element count does not fit the length field");
   end

   for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
      localparam logic [VL_W-1:0] IDX = VL_W'(i);
      always_comb begin
         if (IDX >= vl_i)
            cls_o[i] = CLS_TAIL;
         else if (masked_i && !pred_i[i])
            cls_o[i] = CLS_INACT;
         else
            cls_o[i] = CLS_ACT;
      end
   end

endmodule

// File: rtl/vwp_policy_map.sv
module vwp_policy_map #(
   parameter int unsigned N_ELEM = 16
) (
   input  logic [N_ELEM-1:0][1:0] cls_i,
   input  logic                   tail_agn_i,
   input  logic                   mask_agn_i,
   output logic [N_ELEM-1:0][1:0] act_o
);
   import vwp_pkg::*;

   always_comb begin
      for (int i = 0; i < N_ELEM; i++) begin
         unique case (cls_i[i])
            CLS_ACT:   act_o[i] = ACT_RESULT;
            CLS_INACT: act_o[i] = mask_agn_i ? ACT_ONES : ACT_KEEP;
            default:   act_o[i] = tail_agn_i ? ACT_ONES : ACT_KEEP;
         endcase
      end
   end

endmodule

// File: rtl/vwp_byte_merge.sv
module vwp_byte_merge #(
   parameter int unsigned N_BYTES = 16
) (
   input  logic [N_BYTES-1:0][1:0] act_i,
   input  logic [N_BYTES*8-1:0]    old_i,
   input  logic [N_BYTES*8-1:0]    new_i,
   output logic [N_BYTES-1:0]      we_o,
   output logic [N_BYTES*8-1:0]    data_o
);
   import vwp_pkg::*;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      always_comb begin
         unique case (act_i[b])
            ACT_RESULT: begin
               we_o[b]           = 1'b1;
               data_o[b*8 +: 8]  = new_i[b*8 +: 8];
            end
            ACT_ONES: begin
               we_o[b]           = 1'b1;
               data_o[b*8 +: 8]  = 8'hFF;
            end
            default: begin
               we_o[b]           = 1'b0;
               data_o[b*8 +: 8]  = old_i[b*8 +: 8];
            end
         endcase
      end
   end

endmodule

// File: rtl/vec_wr_policy.sv
module vec_wr_policy #(
   parameter int unsigned VLEN      = 128,
   parameter int unsigned LMUL      = 1,
   parameter int unsigned ELEN      = 64,
   localparam int unsigned GRP_BITS  = VLEN * LMUL,
   localparam int unsigned GRP_BYTES = GRP_BITS / 8,
   localparam int unsigned MAX_ELEM  = GRP_BYTES,
   localparam int unsigned VL_W      = $clog2(MAX_ELEM + 1)
) (
   input  logic [VL_W-1:0]       vl_i,
   input  logic [1:0]            sew_i,
   input  logic                  masked_i,
   input  logic                  tail_agn_i,
   input  logic                  mask_agn_i,
   input  logic [MAX_ELEM-1:0]   v0_i,
   input  logic [GRP_BITS-1:0]   old_data_i,
   input  logic [GRP_BITS-1:0]   new_data_i,
   output logic [GRP_BYTES-1:0]  byte_we_o,
   output logic [GRP_BITS-1:0]   wdata_o,
   output logic [2*MAX_ELEM-1:0] elem_cls_o,
   output logic [2*MAX_ELEM-1:0] elem_act_o
);
   import vwp_pkg::*;

   initial begin
      if (VLEN < 64 || (VLEN & (VLEN - 1)) != 0)
         $fatal(1, "vec_wr_policy: VLEN must be a power of two of at least 64");
      if (LMUL != 1 && LMUL != 2 && LMUL != 4 && LMUL != 8)
         $fatal(1, "vec_wr_policy: LMUL must be 1, 2, 4 or 8");
      if (ELEN < 8 || ELEN > 64 || (ELEN & (ELEN - 1)) != 0)
         $fatal(1, "vec_wr_policy: ELEN must be 8, 16, 32 or 64");
      if (ELEN > VLEN)
         $fatal(1, "vec_wr_policy: ELEN exceeds VLEN");
   end

   logic [N_SEW_CODES-1:0][GRP_BYTES-1:0][1:0] byte_act_v;
   logic [N_SEW_CODES-1:0][MAX_ELEM-1:0][1:0]  slot_cls_v;
   logic [N_SEW_CODES-1:0][MAX_ELEM-1:0][1:0]  slot_act_v;

   for (genvar k = 0; k < N_SEW_CODES; k++) begin : g_sew
      localparam int unsigned N_EL = GRP_BYTES >> k;
      if (sew_bits(k) <= ELEN) begin : g_on
         logic [N_EL-1:0][1:0] cls;
         logic [N_EL-1:0][1:0] act;

         vwp_elem_class #(
            .N_ELEM (N_EL),
            .VL_W   (VL_W)
         ) i_class (
            .vl_i     (vl_i),
            .masked_i (masked_i),
            .pred_i   (v0_i[N_EL-1:0]),
            .cls_o    (cls)
         );

         vwp_policy_map #(
            .N_ELEM (N_EL)
         ) i_policy (
            .cls_i      (cls),
            .tail_agn_i (tail_agn_i),
            .mask_agn_i (mask_agn_i),
            .act_o      (act)
         );

         for (genvar b = 0; b < GRP_BYTES; b++) begin : g_b
            assign byte_act_v[k][b] = act[b >> k];
         end

         for (genvar i = 0; i < MAX_ELEM; i++) begin : g_slot
            if (i < N_EL) begin : g_real
               assign slot_cls_v[k][i] = cls[i];
               assign slot_act_v[k][i] = act[i];
            end else begin : g_absent
               assign slot_cls_v[k][i] = CLS_TAIL;
               assign slot_act_v[k][i] = ACT_KEEP;
            end
         end
      end else begin : g_off
         assign byte_act_v[k] = '0;
         assign slot_cls_v[k] = '0;
         assign slot_act_v[k] = '0;
      end
   end

   logic [GRP_BYTES-1:0][1:0] byte_act;
   assign byte_act   = byte_act_v[sew_i];
   assign elem_cls_o = slot_cls_v[sew_i];
   assign elem_act_o = slot_act_v[sew_i];

   vwp_byte_merge #(
      .N_BYTES (GRP_BYTES)
   ) i_merge (
      .act_i  (byte_act),
      .old_i  (old_data_i),
      .new_i  (new_data_i),
      .we_o   (byte_we_o),
      .data_o (wdata_o)
   );

endmodule

// File: rtl/vec_wr_policy_chk.sv
module vec_wr_policy_chk #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned LMUL = 1,
   localparam int unsigned GRP_BITS  = VLEN * LMUL,
   localparam int unsigned GRP_BYTES = GRP_BITS / 8,
   localparam int unsigned MAX_ELEM  = GRP_BYTES,
   localparam int unsigned VL_W      = $clog2(MAX_ELEM + 1)
) (
   input logic [VL_W-1:0]       vl_i,
   input logic [1:0]            sew_i,
   input logic                  masked_i,
   input logic                  tail_agn_i,
   input logic                  mask_agn_i,
   input logic [MAX_ELEM-1:0]   v0_i,
   input logic [GRP_BITS-1:0]   old_data_i,
   input logic [GRP_BITS-1:0]   new_data_i,
   input logic [GRP_BYTES-1:0]  byte_we_o,
   input logic [GRP_BITS-1:0]   wdata_o,
   input logic [2*MAX_ELEM-1:0] elem_cls_o,
   input logic [2*MAX_ELEM-1:0] elem_act_o
);
   logic known;
   assign known = !$isunknown({vl_i, sew_i, masked_i, tail_agn_i, mask_agn_i,
                               v0_i, old_data_i, new_data_i});

   always_comb begin
      if (known) begin
         for (int b = 0; b < GRP_BYTES; b++) begin
            // R2 / R5: an unwritten byte carries the old data
            a_r2_keep_old: assert (byte_we_o[b] || wdata_o[b*8 +: 8] == old_data_i[b*8 +: 8]);
            // R3 / R4 / R6: a written byte carries either the result or the fill
            a_r3_written_value: assert (!byte_we_o[b] ||
                                        wdata_o[b*8 +: 8] == new_data_i[b*8 +: 8] ||
                                        wdata_o[b*8 +: 8] == 8'hFF);
         end
         for (int i = 0; i < MAX_ELEM; i++) begin
            // R1: a slot at or beyond vl reads as tail
            a_r1_tail_from_vl: assert (VL_W'(i) < vl_i || elem_cls_o[2*i +: 2] == 2'd0);
            // R7: no inactive element without predication
            a_r7_unmasked_no_inactive: assert (masked_i || elem_cls_o[2*i +: 2] != 2'd2);
         end
         // R9: empty vector length under keep-old tail policy writes nothing
         a_r9_empty_vl: assert (vl_i != '0 || tail_agn_i || byte_we_o == '0);
      end
   end

endmodule

bind vec_wr_policy vec_wr_policy_chk #(
   .VLEN (VLEN),
   .LMUL (LMUL)
) i_chk (
   .vl_i       (vl_i),
   .sew_i      (sew_i),
   .masked_i   (masked_i),
   .tail_agn_i (tail_agn_i),
   .mask_agn_i (mask_agn_i),
   .v0_i       (v0_i),
   .old_data_i (old_data_i),
   .new_data_i (new_data_i),
   .byte_we_o  (byte_we_o),
   .wdata_o    (wdata_o),
   .elem_cls_o (elem_cls_o),
   .elem_act_o (elem_act_o)
);

// File: tb/test_vec_wr_policy.sv
module test_vec_wr_policy;
   localparam int unsigned GB   = 16;
   localparam int unsigned GBIT = 128;
   localparam int unsigned ME   = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [4:0]      vl;
   logic [1:0]      sew;
   logic            masked, ta, ma;
   logic [ME-1:0]   v0;
   logic [GBIT-1:0] old_d, new_d;
   logic [GB-1:0]   we;
   logic [GBIT-1:0] wd;
   logic [2*ME-1:0] cls, act;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   vec_wr_policy i_vec_wr_policy (
      .vl_i(vl), .sew_i(sew), .masked_i(masked), .tail_agn_i(ta), .mask_agn_i(ma),
      .v0_i(v0), .old_data_i(old_d), .new_data_i(new_d),
      .byte_we_o(we), .wdata_o(wd), .elem_cls_o(cls), .elem_act_o(act)
   );

   logic [GB-1:0]   e_we;
   logic [GBIT-1:0] e_wd;
   logic [2*ME-1:0] e_cls, e_act;

   task automatic model();
      int nel;
      logic [1:0] c, a;
      nel = GB >> sew;
      for (int e = 0; e < ME; e++) begin
         if (e >= nel) begin c = 2'd0; a = 2'd0; end
         else begin
            if (e >= vl)                 c = 2'd0;
            else if (masked && !v0[e])   c = 2'd2;
            else                         c = 2'd1;
            a = (c == 2'd1) ? 2'd1 : (c == 2'd2) ? (ma ? 2'd2 : 2'd0) : (ta ? 2'd2 : 2'd0);
         end
         e_cls[2*e +: 2] = c;
         e_act[2*e +: 2] = a;
      end
      for (int b = 0; b < GB; b++) begin
         logic [1:0] ba;
         ba = e_act[2*(b >> sew) +: 2];
         e_we[b] = (ba != 2'd0);
         e_wd[b*8 +: 8] = (ba == 2'd1) ? new_d[b*8 +: 8] :
                          (ba == 2'd2) ? 8'hFF : old_d[b*8 +: 8];
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic [GBIT-1:0] got, input logic [GBIT-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic apply(input string req, input logic [1:0] s, input logic [4:0] l,
                        input logic m, input logic t, input logic a, input logic [ME-1:0] p);
      @(negedge clk);
      sew = s; vl = l; masked = m; ta = t; ma = a; v0 = p;
      old_d = {4{32'hA5C3_1E70}} ^ {GBIT{l[0]}};
      new_d = {32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_F001};
      #5;
      model();
      chk(req, "byte_we", GBIT'(we), GBIT'(e_we));
      chk(req, "wdata", wd, e_wd);
      chk(req, "elem_cls", GBIT'(cls), GBIT'(e_cls));
      chk(req, "elem_act", GBIT'(act), GBIT'(e_act));
   endtask

   // R9 / R2: reset-like all-zero inputs write nothing
   task automatic t_idle();
      apply("R9", 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, '0);
      chk("R2", "no write at vl=0", GBIT'(we), '0);
   endtask

   // R1 / R2: tail kept at 8-bit elements
   task automatic t_tail_keep();
      apply("R1", 2'd0, 5'd5, 1'b0, 1'b0, 1'b0, '0);
      chk("R2", "tail byte 5 kept", GBIT'(wd[47:40]), GBIT'(old_d[47:40]));
      chk("R1", "slot 5 tail", GBIT'(cls[11:10]), 128'd0);
   endtask

   // R3 / R8: tail fill at 16-bit elements
   task automatic t_tail_fill();
      apply("R3", 2'd1, 5'd3, 1'b0, 1'b1, 1'b0, '0);
      chk("R3", "elem 3 filled", GBIT'(wd[63:48]), GBIT'(16'hFFFF));
      chk("R8", "elem 2 result", GBIT'(wd[47:32]), GBIT'(new_d[47:32]));
   endtask

   // R4 / R5: predicated, keep-old inactive at 32-bit elements
   task automatic t_pred_keep();
      apply("R5", 2'd2, 5'd4, 1'b1, 1'b0, 1'b0, 16'b0101);
      chk("R4", "elem 0 active", GBIT'(wd[31:0]), GBIT'(new_d[31:0]));
      chk("R5", "elem 1 kept", GBIT'(wd[63:32]), GBIT'(old_d[63:32]));
   endtask

   // R6: predicated, fill inactive at 64-bit elements
   task automatic t_pred_fill();
      apply("R6", 2'd3, 5'd2, 1'b1, 1'b0, 1'b1, 16'b10);
      chk("R6", "elem 0 filled", GBIT'(wd[63:0]), GBIT'(64'hFFFF_FFFF_FFFF_FFFF));
   endtask

   // R7: unpredicated ignores v0
   task automatic t_unpred();
      apply("R7", 2'd0, 5'd10, 1'b0, 1'b1, 1'b1, 16'h0000);
      apply("R7", 2'd2, 5'd3, 1'b0, 1'b0, 1'b1, 16'hAAAA);
   endtask

   // R9: full and over-long vector length leaves no tail
   task automatic t_full();
      apply("R9", 2'd0, 5'd16, 1'b0, 1'b1, 1'b0, '0);
      apply("R9", 2'd2, 5'd16, 1'b1, 1'b1, 1'b0, 16'b1001);
   endtask

   // R10 / R8: absent slots at wide elements
   task automatic t_absent();
      apply("R10", 2'd3, 5'd16, 1'b0, 1'b1, 1'b1, '1);
      chk("R10", "slot 2 absent", GBIT'(act[5:4]), 128'd0);
      apply("R8", 2'd1, 5'd6, 1'b1, 1'b1, 1'b0, 16'b1100_1010);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_idle();
      t_tail_keep();
      t_tail_fill();
      t_pred_keep();
      t_pred_fill();
      t_unpred();
      t_full();
      t_absent();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule